// File: doc/BRIEF.md
# Byte-Accessed 16-bit Up/Down Timer Counter

This block is a 16-bit counter that a processor with an 8-bit data bus reads and writes one byte at a time. The counter steps up or down by one, or is cleared to zero, on each timer tick. A 3-bit source selector picks the tick. Code zero stops the counter. Codes 1 to 5 pass one of five prescaler enable taps. Codes 6 and 7 count the falling or rising edges of an external pin, which is first brought into the clock domain through a two-flop synchronizer.

The bus has two byte addresses. The low-byte address reaches the live counter bits 7:0. The high-byte address reaches only an 8-bit shadow register and never the live upper byte. A low-byte read copies the live upper byte into the shadow in the same clock. A low-byte write loads the live upper byte from the shadow together with the written low byte. Software therefore reads low then high, and writes high then low, and always sees or sets an untorn 16-bit value while the counter runs.

Two flags show when the count is at its maximum and at zero. A one-clock overflow pulse marks an up-count that wraps to zero.

Top module: `byte_counter16`

## Requirements
- R1: With direction up (`dir_down`=0), each timer tick adds one to the counter.
- R2: With direction down (`dir_down`=1), each timer tick subtracts one from the counter.
- R3: The count wraps modulo 2^16. An up-step from 0xFFFF to 0x0000 raises `ovf_pulse` for exactly one clock, in the cycle the counter first reads 0x0000. A down-step from 0x0000 to 0xFFFF raises no pulse.
- R4: On a tick with `clr` high and no CPU write, the counter becomes 0, whatever the direction. Clear takes precedence over count. Without a tick, `clr` has no effect.
- R5: Source code 0 produces no tick, so the counter holds its value. CPU reads and writes still work in this state.
- R6: Bus address 1 is the high-byte address. A write there changes only the shadow byte and leaves the live counter unchanged. A read there returns the shadow byte.
- R7: Bus address 0 is the low-byte address. A read there returns live counter bits 7:0 and, at the same clock edge, copies live bits 15:8 into the shadow byte.
- R8: A low-byte write sets the counter to {shadow byte, written byte} in a single clock.
- R9: A CPU low-byte write takes priority over a count or a clear in the same cycle.
- R10: `cnt_top` is high exactly when the counter equals 0xFFFF. `cnt_bottom` is high exactly when it equals 0x0000.
- R11: Source codes 1 to 5 tick in every cycle in which `tap_en[code-1]` is high.
- R12: Source code 6 ticks once per falling edge and code 7 once per rising edge of `ext_pin`, after a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 3 | Tick source: 0 stop, 1-5 prescaler taps, 6 pin falling edge, 7 pin rising edge |
| tap_en | input | 5 | Prescaler enable taps, bit i used by code i+1 |
| ext_pin | input | 1 | External count pin, asynchronous |
| dir_down | input | 1 | 0 count up, 1 count down |
| clr | input | 1 | Clear request, acts on a tick |
| bus_addr | input | 1 | 0 low byte, 1 high byte (shadow) |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| cnt_top | output | 1 | Counter at maximum |
| cnt_bottom | output | 1 | Counter at zero |
| ovf_pulse | output | 1 | One-clock up-wrap pulse |

## Verification
A corrupted shadow byte does not appear until the next high-byte read or low-byte write, so the tests read it back right after each access that should set it. A counter that takes a wrong step, misses a stop or loses a priority decision shows on the limit flags at once, and on the low-byte read data in the next cycle. The untorn-access tests run the counter across a carry from the low byte into the high byte during a read and during a write. A design that lets the live upper byte leak onto the bus gives a different 16-bit value than the bench expects. Edge-source faults show as a count that differs from the number of pin edges a few cycles after the pin settles.

// File: rtl/cnt16_pkg.sv
`timescale 1ns/1ps
package cnt16_pkg;
    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_STOP = 3'd0;
    localparam logic [SEL_W-1:0] SEL_FALL = 3'd6;
    localparam logic [SEL_W-1:0] SEL_RISE = 3'd7;
    localparam logic ADDR_LO = 1'b0;
    localparam logic ADDR_HI = 1'b1;
endpackage

// File: rtl/cnt_src_sel.sv
`timescale 1ns/1ps
module cnt_src_sel
    import cnt16_pkg::*;
#(
    parameter int TAP_N  = 5,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic [TAP_N-1:0] tap_en,
    input  logic             ext_pin,
    output logic             tick
);
    localparam int PIPE_W = SYNC_N + 1;

    typedef struct packed {
        logic [PIPE_W-1:0] pipe;
    } src_st_t;

    src_st_t st_d, st_q;
    logic synced, prev, rise, fall;

    assign synced = st_q.pipe[SYNC_N-1];
    assign prev   = st_q.pipe[SYNC_N];
    assign rise   = synced & ~prev;
    assign fall   = ~synced & prev;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[PIPE_W-2:0], ext_pin};
        tick      = 1'b0;
        if (sel == SEL_RISE) begin
            tick = rise;
        end else if (sel == SEL_FALL) begin
            tick = fall;
        end else begin
            for (int i = 0; i < TAP_N; i++) begin
                if (int'(sel) == i + 1) tick = tap_en[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R12: an edge tick needs the pin at the new level two clocks earlier
    p_rise_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_RISE && tick) |-> (synced && !prev));
    p_stop_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_STOP) |-> !tick);
endmodule

// File: rtl/cnt_core.sv
`timescale 1ns/1ps
module cnt_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             dir_down,
    input  logic             clr,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt,
    output logic             at_top,
    output logic             at_bottom,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        if (ld) begin
            st_d.cnt = ld_val;
        end else if (tick) begin
            if (clr) begin
                st_d.cnt = '0;
            end else if (dir_down) begin
                st_d.cnt = st_q.cnt - ONE;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
                st_d.ovf = (st_q.cnt == CNT_MAX);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt       = st_q.cnt;
    assign ovf       = st_q.ovf;
    assign at_top    = (st_q.cnt == CNT_MAX);
    assign at_bottom = (st_q.cnt == '0);

    p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt == $past(ld_val)));
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && clr && !ld) |=> (cnt == '0));
    p_up_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && !ld && !dir_down) |=> (cnt == $past(cnt) + ONE));
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld) |=> $stable(cnt));
    p_ovf_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> at_bottom);
endmodule

// File: rtl/cnt_byte_if.sv
`timescale 1ns/1ps
module cnt_byte_if
    import cnt16_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr,
    input  logic               rd,
    input  logic               wr,
    input  logic [BUS_W-1:0]   wdata,
    input  logic [2*BUS_W-1:0] cnt,
    output logic [BUS_W-1:0]   rdata,
    output logic               ld,
    output logic [2*BUS_W-1:0] ld_val
);
    localparam int CNT_W = 2 * BUS_W;

    typedef struct packed {
        logic [BUS_W-1:0] shadow;
    } bif_st_t;

    bif_st_t st_d, st_q;
    logic [BUS_W-1:0] live_hi;

    assign live_hi = cnt[CNT_W-1:BUS_W];

    always_comb begin
        st_d   = st_q;
        ld     = 1'b0;
        ld_val = {st_q.shadow, wdata};
        if (wr) begin
            if (addr == ADDR_HI) st_d.shadow = wdata;
            else                 ld = 1'b1;
        end else if (rd && addr == ADDR_LO) begin
            st_d.shadow = live_hi;
        end
        rdata = (addr == ADDR_HI) ? st_q.shadow : cnt[BUS_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr && addr == ADDR_LO) |=> (st_q.shadow == $past(live_hi)));
    p_hi_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_HI) |=> (st_q.shadow == $past(wdata)));
    p_hi_no_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_HI) |-> !ld);
endmodule

// File: rtl/byte_counter16.sv
`timescale 1ns/1ps
module byte_counter16
    import cnt16_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int TAP_N  = 5,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       src_sel,
    input  logic [TAP_N-1:0] tap_en,
    input  logic             ext_pin,
    input  logic             dir_down,
    input  logic             clr,
    input  logic             bus_addr,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             cnt_top,
    output logic             cnt_bottom,
    output logic             ovf_pulse
);
    localparam int CNT_W = 2 * BUS_W;

    logic             tick;
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic [CNT_W-1:0] cnt;

    cnt_src_sel #(.TAP_N(TAP_N), .SYNC_N(SYNC_N)) u_src (
        .clk(clk), .rst_n(rst_n), .sel(src_sel), .tap_en(tap_en),
        .ext_pin(ext_pin), .tick(tick)
    );

    cnt_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .dir_down(dir_down),
        .clr(clr), .ld(ld), .ld_val(ld_val), .cnt(cnt),
        .at_top(cnt_top), .at_bottom(cnt_bottom), .ovf(ovf_pulse)
    );

    cnt_byte_if #(.BUS_W(BUS_W)) u_bif (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
        .wdata(bus_wdata), .cnt(cnt), .rdata(bus_rdata), .ld(ld), .ld_val(ld_val)
    );

    p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cnt_top && cnt_bottom));
    p_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == SEL_STOP && !(bus_wr && bus_addr == ADDR_LO)) |=> $stable(cnt));
endmodule

// File: tb/test_byte_counter16.sv
`timescale 1ns/1ps
module test_byte_counter16;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] src_sel = 3'd0;
    logic [4:0] tap_en = 5'd0;
    logic       ext_pin = 1'b0;
    logic       dir_down = 1'b0;
    logic       clr = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       cnt_top, cnt_bottom, ovf_pulse;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    byte_counter16 i_byte_counter16 (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .tap_en(tap_en),
        .ext_pin(ext_pin), .dir_down(dir_down), .clr(clr),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_top(cnt_top), .cnt_bottom(cnt_bottom), .ovf_pulse(ovf_pulse)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic write16(input logic [15:0] v);
        @(negedge clk); bus_addr = 1'b1; bus_wr = 1'b1; bus_wdata = v[15:8];
        @(negedge clk); bus_addr = 1'b0; bus_wdata = v[7:0];
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic read16(output logic [15:0] v);
        @(negedge clk); bus_addr = 1'b0; bus_rd = 1'b1;
        #1 v[7:0] = bus_rdata;
        @(negedge clk); bus_addr = 1'b1;
        #1 v[15:8] = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic run_ticks(input logic [2:0] code, input int n);
        @(negedge clk); src_sel = code;
        repeat (n) @(negedge clk);
        src_sel = 3'd0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R10 bottom at reset", {15'd0, cnt_bottom}, 16'd1);
        chk("R3 no ovf at reset", {15'd0, ovf_pulse}, 16'd0);
        read16(v);
        chk("R7 reset value", v, 16'h0000);
    endtask

    task automatic t_up_down();
        logic [15:0] v;
        tap_en = 5'b11111; dir_down = 1'b0;
        write16(16'h0010);
        run_ticks(3'd1, 5);
        read16(v); chk("R1 up five ticks", v, 16'h0015);
        dir_down = 1'b1;
        run_ticks(3'd1, 3);
        read16(v); chk("R2 down three ticks", v, 16'h0012);
        dir_down = 1'b0;
    endtask

    task automatic t_taps();
        logic [15:0] v;
        write16(16'h0200);
        tap_en = 5'b00100;
        run_ticks(3'd3, 4);
        read16(v); chk("R11 code3 uses tap2", v, 16'h0204);
        tap_en = 5'b11011;
        run_ticks(3'd3, 4);
        read16(v); chk("R11 code3 tap low", v, 16'h0204);
        tap_en = 5'b10000;
        run_ticks(3'd5, 2);
        read16(v); chk("R11 code5 uses tap4", v, 16'h0206);
        tap_en = 5'b11111;
    endtask

    task automatic t_wrap();
        logic [15:0] v;
        dir_down = 1'b0;
        write16(16'hFFFE);
        run_ticks(3'd1, 1);
        chk("R10 top at FFFF", {14'd0, cnt_top, cnt_bottom}, 16'h0002);
        run_ticks(3'd1, 1);
        chk("R3 ovf on up wrap", {15'd0, ovf_pulse}, 16'd1);
        chk("R10 bottom after wrap", {14'd0, cnt_top, cnt_bottom}, 16'h0001);
        @(negedge clk);
        chk("R3 ovf one clock", {15'd0, ovf_pulse}, 16'd0);
        write16(16'h0000);
        dir_down = 1'b1;
        run_ticks(3'd1, 1);
        chk("R3 no ovf on down wrap", {15'd0, ovf_pulse}, 16'd0);
        read16(v); chk("R3 down wrap value", v, 16'hFFFF);
        dir_down = 1'b0;
    endtask

    task automatic t_clear_stop();
        logic [15:0] v;
        write16(16'h4321);
        clr = 1'b1;
        repeat (3) @(negedge clk);
        clr = 1'b0;
        read16(v); chk("R4 clear without tick ignored", v, 16'h4321);
        repeat (3) @(negedge clk);
        read16(v); chk("R5 stopped holds", v, 16'h4321);
        clr = 1'b1;
        run_ticks(3'd1, 1);
        clr = 1'b0;
        read16(v); chk("R4 clear beats count", v, 16'h0000);
    endtask

    task automatic t_shadow();
        logic [15:0] v;
        write16(16'h1234);
        @(negedge clk); bus_addr = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h55;
        @(negedge clk); bus_wr = 1'b0;
        chk("R6 hi write leaves counter", {14'd0, cnt_top, cnt_bottom}, 16'h0000);
        bus_rd = 1'b1;
        #1 chk("R6 hi read returns shadow", {8'd0, bus_rdata}, 16'h0055);
        @(negedge clk); bus_rd = 1'b0;
        read16(v); chk("R6 live value unchanged", v, 16'h1234);
        write16(16'hA0B1);
        read16(v); chk("R8 low write commits pair", v, 16'hA0B1);
    endtask

    task automatic t_untorn_read();
        logic [15:0] v;
        write16(16'h00FF);
        tap_en = 5'b11111; dir_down = 1'b0;
        @(negedge clk); src_sel = 3'd1; bus_addr = 1'b0; bus_rd = 1'b1;
        #1 v[7:0] = bus_rdata;
        @(negedge clk); bus_addr = 1'b1;
        #1 v[15:8] = bus_rdata;
        @(negedge clk); bus_rd = 1'b0; src_sel = 3'd0;
        chk("R7 untorn read across carry", v, 16'h00FF);
    endtask

    task automatic t_untorn_write();
        logic [15:0] v;
        write16(16'h12FE);
        @(negedge clk); src_sel = 3'd1;
        write16(16'hABCD);
        src_sel = 3'd0;
        read16(v); chk("R9 write beats count", v, 16'hABCD);
        @(negedge clk); src_sel = 3'd1; clr = 1'b1;
        write16(16'h5A5A);
        src_sel = 3'd0; clr = 1'b0;
        read16(v); chk("R9 write beats clear", v, 16'h5A5A);
    endtask

    task automatic t_ext();
        logic [15:0] v;
        write16(16'h0100);
        @(negedge clk); src_sel = 3'd7;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); ext_pin = 1'b1;
            repeat (4) @(negedge clk);
            ext_pin = 1'b0;
            repeat (4) @(negedge clk);
        end
        src_sel = 3'd0;
        read16(v); chk("R12 rising edges", v, 16'h0103);
        @(negedge clk); src_sel = 3'd6;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); ext_pin = 1'b1;
            repeat (4) @(negedge clk);
            ext_pin = 1'b0;
            repeat (4) @(negedge clk);
        end
        src_sel = 3'd0;
        read16(v); chk("R12 falling edges", v, 16'h0105);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_up_down();
        t_taps();
        t_wrap();
        t_clear_stop();
        t_shadow();
        t_untorn_read();
        t_untorn_write();
        t_ext();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule